// File: doc/BRIEF.md
# FIFO Entry-Order Tracking Monitor

This block watches a FIFO from the outside and checks that one chosen word leaves the queue intact and in its proper turn. It does not keep a copy of the queue. A free trigger input picks the word: when the trigger is high in a cycle that also carries a write transfer, the monitor stores that word. It also stores how many entries must leave the FIFO before that word reaches the read side. From then on it counts read transfers. When the tracked word is due, the monitor compares the read data with its stored copy and reports pass or fail.

The monitor only observes both FIFO ports, which use valid/ready handshakes, and never drives a ready. A beat is a transfer only in a cycle where its valid and ready are both high. A beat held back by a low ready is neither captured nor counted, however long it waits. The monitor also takes the FIFO's occupancy, which it reads as the number of entries stored before the current cycle's transfers. Whatever the FIFO depth, its state is one data word, one position counter and a two-bit control state.

A pass is reported for one cycle, after which the monitor is idle and can track another entry. A fail holds until reset, so a single corrupted or reordered word stays visible. In a flow with free inputs, the trigger lets any entry be the tracked one.

Top module: `fifo_order_tracker`

## Requirements
- R1: While idle (busy, pass and fail all low), the monitor stays idle unless the trigger and a write transfer (push_valid_i and push_ready_i both high) occur in the same cycle.
- R2: On the arming cycle the monitor stores push_data_i and loads its position counter with occupancy_i + 1. busy_o is high from the next cycle.
- R3: While busy, each read transfer (pop_valid_i and pop_ready_i both high) taken while the counter is above 1 lowers the counter by one. busy_o stays high and pass_o and fail_o stay low.
- R4: A read transfer taken while the counter is 1, with pop_data_i equal to the stored word, raises pass_o for exactly one cycle. In the cycle after that pulse, busy_o, pass_o and fail_o are all low.
- R5: A read transfer taken while the counter is 1, with pop_data_i different from the stored word, raises fail_o. fail_o then stays high, and busy_o and pass_o stay low, until reset.
- R6: A trigger seen while busy, passing or failing is ignored. It neither reloads the counter nor replaces the stored word.
- R7: If the arming cycle also carries a read transfer, the counter is loaded with occupancy_i, one less than in R2.
- R8: A valid beat with its ready low is not a transfer. A write beat blocked by a full FIFO cannot arm the monitor, and a read beat held with pop_ready_i low is not counted.
- R9: While rst_n is low, and in the first cycle after it, busy_o, pass_o and fail_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Free selection input; arms the monitor on a write transfer |
| push_valid_i | input | 1 | FIFO write side valid |
| push_ready_i | input | 1 | FIFO write side ready |
| push_data_i | input | DATA_W | FIFO write data |
| pop_valid_i | input | 1 | FIFO read side valid |
| pop_ready_i | input | 1 | FIFO read side ready |
| pop_data_i | input | DATA_W | FIFO read data |
| occupancy_i | input | OCC_W | Entries stored before this cycle's transfers |
| pass_o | output | 1 | One-cycle pulse: tracked word left intact |
| fail_o | output | 1 | Sticky: tracked word arrived wrong |
| busy_o | output | 1 | A word is being tracked |

## Verification
The bench builds the monitor with DATA_W = 16 and DEPTH = 8, next to an eight-entry reference FIFO whose read data can be corrupted on purpose. With this shallow depth the FIFO fills after a few writes. A blocked write with the trigger high and a stalled read beat can then be tried, and the largest counter load of eight can be tracked to its end. Each scenario exercises a different counter load: an empty queue, a queue three deep, a capture that shares its cycle with a read, and a full queue.

// File: rtl/fifo_trk_pkg.sv
package fifo_trk_pkg;

  typedef enum logic [1:0] {
    TRK_IDLE   = 2'd0,
    TRK_FOLLOW = 2'd1,
    TRK_PASS   = 2'd2,
    TRK_FAIL   = 2'd3
  } trk_state_t;

  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 2);
  endfunction

endpackage

// File: rtl/fifo_trk_snap.sv
module fifo_trk_snap #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] snap_q,
  output logic              same
);

  logic [DATA_W-1:0] diff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (capture) begin
      snap_q <= wr_data;
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign diff[b] = snap_q[b] ^ rd_data[b];
  end

  assign same = (diff == '0);

endmodule

// File: rtl/fifo_trk_count.sv
module fifo_trk_count #(
  parameter int unsigned OCC_W = 4,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OCC_W-1:0] occ,
  input  logic             rd_fire,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_last
);

  logic [CNT_W-1:0] load_val;

  always_comb begin
    load_val = CNT_W'(occ) + CNT_W'(1);
    if (rd_fire) begin
      load_val = load_val - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step && !at_last) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign at_last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/fifo_trk_ctrl.sv
module fifo_trk_ctrl
  import fifo_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_req,
  input  logic       rd_fire,
  input  logic       at_last,
  input  logic       same,
  output logic       capture,
  output logic       step,
  output trk_state_t state_q
);

  trk_state_t state_d;

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      TRK_IDLE: begin
        if (arm_req) begin
          capture = 1'b1;
          state_d = TRK_FOLLOW;
        end
      end
      TRK_FOLLOW: begin
        if (rd_fire) begin
          step = 1'b1;
          if (at_last) begin
            state_d = same ? TRK_PASS : TRK_FAIL;
          end
        end
      end
      TRK_PASS: state_d = TRK_IDLE;
      TRK_FAIL: state_d = TRK_FAIL;
      default:  state_d = TRK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TRK_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/fifo_order_tracker.sv
module fifo_order_tracker
  import fifo_trk_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              push_valid_i,
  input  logic              push_ready_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_valid_i,
  input  logic              pop_ready_i,
  input  logic [DATA_W-1:0] pop_data_i,
  input  logic [OCC_W-1:0]  occupancy_i,
  output logic              pass_o,
  output logic              fail_o,
  output logic              busy_o
);

  localparam int unsigned CNT_W = cnt_width(DEPTH);

  logic              wr_fire;
  logic              rd_fire;
  logic              arm_req;
  logic              capture;
  logic              step;
  logic              at_last;
  logic              same;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] snap_q;
  trk_state_t        state_q;

  assign wr_fire = push_valid_i & push_ready_i;
  assign rd_fire = pop_valid_i & pop_ready_i;
  assign arm_req = trig_i & wr_fire;

  fifo_trk_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_req (arm_req),
    .rd_fire (rd_fire),
    .at_last (at_last),
    .same    (same),
    .capture (capture),
    .step    (step),
    .state_q (state_q)
  );

  fifo_trk_snap #(.DATA_W(DATA_W)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .wr_data (push_data_i),
    .rd_data (pop_data_i),
    .snap_q  (snap_q),
    .same    (same)
  );

  fifo_trk_count #(.OCC_W(OCC_W), .CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (capture),
    .occ     (occupancy_i),
    .rd_fire (rd_fire),
    .step    (step),
    .cnt_q   (cnt_q),
    .at_last (at_last)
  );

  assign busy_o = (state_q == TRK_FOLLOW);
  assign pass_o = (state_q == TRK_PASS);
  assign fail_o = (state_q == TRK_FAIL);

endmodule

// File: rtl/fifo_order_tracker_chk.sv
module fifo_order_tracker_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OCC_W  = 4,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_i,
  input logic              push_valid_i,
  input logic              push_ready_i,
  input logic              pop_valid_i,
  input logic              pop_ready_i,
  input logic [DATA_W-1:0] pop_data_i,
  input logic [OCC_W-1:0]  occupancy_i,
  input logic              pass_o,
  input logic              fail_o,
  input logic              busy_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] snap
);

  logic idle, wfire, rfire;
  assign idle  = !busy_o && !pass_o && !fail_o;
  assign wfire = push_valid_i && push_ready_i;
  assign rfire = pop_valid_i && pop_ready_i;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    idle && !(trig_i && wfire) |=> idle); // R1

  AST_ARM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    idle && trig_i && wfire |=> busy_o &&
      (32'(cnt) == 32'($past(occupancy_i)) + 1 - 32'($past(rfire)))); // R2 R7

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && rfire && cnt > 1 |=> busy_o && cnt == $past(cnt) - 1); // R3

  AST_LAST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && rfire && cnt == 1 && pop_data_i == snap |=> pass_o); // R4

  AST_PASS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |=> idle); // R4

  AST_LAST_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && rfire && cnt == 1 && pop_data_i != snap |=> fail_o); // R5

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> fail_o && !busy_o && !pass_o); // R5

  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && trig_i && wfire && !rfire |=> busy_o && $stable(cnt) && $stable(snap)); // R6

  AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    idle && !push_ready_i |=> idle); // R8

endmodule

bind fifo_order_tracker fifo_order_tracker_chk #(
  .DATA_W(DATA_W), .OCC_W(OCC_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .trig_i       (trig_i),
  .push_valid_i (push_valid_i),
  .push_ready_i (push_ready_i),
  .pop_valid_i  (pop_valid_i),
  .pop_ready_i  (pop_ready_i),
  .pop_data_i   (pop_data_i),
  .occupancy_i  (occupancy_i),
  .pass_o       (pass_o),
  .fail_o       (fail_o),
  .busy_o       (busy_o),
  .cnt          (cnt_q),
  .snap         (snap_q)
);

// File: tb/tb_fifo_order_tracker.sv
module tb_fifo_order_tracker;

  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int OW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tg = 1'b0, pv = 1'b0, pr = 1'b0;
  logic [DW-1:0] pd = '0, flip = '0;
  logic          push_ready, pop_valid;
  logic [DW-1:0] pop_data;
  logic [OW-1:0] count;
  logic          pass, fail, busy;

  logic [DW-1:0] mem [DEPTH];
  logic [2:0]    wr, rd;
  int            errs = 0, checks = 0;

  always #2 clk = ~clk;

  assign push_ready = (count < OW'(DEPTH));
  assign pop_valid  = (count != '0);
  assign pop_data   = mem[rd] ^ flip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr <= '0; rd <= '0; count <= '0;
    end else begin
      if (pv && push_ready) begin
        mem[wr] <= pd;
        wr <= wr + 3'd1;
      end
      if (pop_valid && pr) rd <= rd + 3'd1;
      count <= count + OW'(pv && push_ready) - OW'(pop_valid && pr);
    end
  end

  fifo_order_tracker #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .trig_i(tg),
    .push_valid_i(pv), .push_ready_i(push_ready), .push_data_i(pd),
    .pop_valid_i(pop_valid), .pop_ready_i(pr), .pop_data_i(pop_data),
    .occupancy_i(count), .pass_o(pass), .fail_o(fail), .busy_o(busy)
  );

  task automatic chk(input string tag, input logic [2:0] exp);
    checks++;
    if ({busy, pass, fail} !== exp) begin
      errs++;
      $display("FAIL %s: {busy,pass,fail} actual=%b expected=%b", tag, {busy, pass, fail}, exp);
    end
  endtask

  task automatic step(input logic p, input logic [DW-1:0] d, input logic q, input logic t);
    @(negedge clk);
    pv = p; pd = d; pr = q; tg = t;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pv = 0; pr = 0; tg = 0; flip = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R9 during reset", 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    pv = 0; pr = 0; tg = 0;
    @(posedge clk);
    #1;
    chk("R9 after reset", 3'b000);
  endtask

  task automatic t_single();
    do_reset();
    step(1, 16'h00A5, 0, 1); chk("R2 arm on empty", 3'b100);
    step(0, 0, 1, 0);        chk("R4 match pass", 3'b010);
    step(0, 0, 0, 0);        chk("R4 back to idle", 3'b000);
  endtask

  task automatic t_deep();
    do_reset();
    for (int i = 0; i < 3; i++) begin
      step(1, 16'(i + 1), 0, 0); chk("R1 push without trigger", 3'b000);
    end
    step(1, 16'h1234, 0, 1); chk("R2 arm at depth 3", 3'b100);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 1, 0); chk("R3 count down", 3'b100);
    end
    step(0, 0, 1, 0); chk("R4 pass on fourth read", 3'b010);
    step(0, 0, 0, 0); chk("R4 idle again", 3'b000);
  endtask

  task automatic t_trig_only();
    do_reset();
    step(0, 16'h7777, 0, 1); chk("R1 trigger without push", 3'b000);
    step(0, 0, 0, 0);        chk("R1 still idle", 3'b000);
  endtask

  task automatic t_ignore();
    do_reset();
    step(1, 16'h0AAA, 0, 1); chk("R2 arm on first", 3'b100);
    step(1, 16'h0BBB, 0, 1); chk("R6 second trigger ignored", 3'b100);
    step(0, 0, 1, 0);        chk("R6 pass at first word", 3'b010);
    step(0, 0, 1, 0);        chk("R6 no tracking of second", 3'b000);
  endtask

  task automatic t_same_cycle_pop();
    do_reset();
    step(1, 16'h0011, 0, 0);
    step(1, 16'h0022, 0, 0);
    step(1, 16'h0C0C, 1, 1); chk("R7 arm with read", 3'b100);
    step(0, 0, 1, 0);        chk("R7 one read left", 3'b100);
    step(0, 0, 1, 0);        chk("R7 pass after two reads", 3'b010);
  endtask

  task automatic t_fault();
    do_reset();
    step(1, 16'h00FF, 0, 1); chk("R2 arm before fault", 3'b100);
    flip = 16'h0001;
    step(0, 0, 1, 0);        chk("R5 mismatch fail", 3'b001);
    flip = '0;
    step(1, 16'h0101, 0, 1); chk("R5 fail sticky under trigger", 3'b001);
    step(0, 0, 1, 0);        chk("R5 fail sticky under read", 3'b001);
    do_reset();
  endtask

  task automatic t_handshake();
    do_reset();
    for (int i = 0; i < DEPTH; i++) step(1, 16'(16'h0100 + i), 0, 0);
    step(1, 16'h0EEE, 0, 1); chk("R8 blocked write cannot arm", 3'b000);
    step(0, 0, 1, 0);        chk("R8 idle read", 3'b000);
    step(1, 16'h0E0E, 0, 1); chk("R8 arm at depth 7", 3'b100);
    step(0, 0, 0, 0);        chk("R8 stalled read not counted", 3'b100);
    for (int i = 0; i < 7; i++) begin
      step(0, 0, 1, 0); chk("R8 R3 count down", 3'b100);
    end
    step(0, 0, 1, 0); chk("R8 pass on eighth read", 3'b010);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_single();
    t_deep();
    t_trig_only();
    t_ignore();
    t_same_cycle_pop();
    t_fault();
    t_handshake();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule